// File: doc/BRIEF.md
# Q15 Fractional Multiply-Add Unit

This block is a two-stage pipelined arithmetic unit for signed Q15 fractional data. Each value is a 16-bit two's complement word: the sign is in the MSB and 15 bits are fractional, so a value lies between -1 and just under +1. Each issued operation is either a multiply or a saturating add.

The multiply forms the full 32-bit Q30 product. It adds a rounding constant one position below the retained LSB, shifts the sum right arithmetically by 15, and clips the result to the Q15 range. The add sums the two operands in Q15 and clips the result to the largest or smallest Q15 value on signed overflow, so it never wraps. Both operations take two cycles from issue to result.

Every clip sets a sticky saturation flag in a small status word that software can read. The flag is cleared only by writing the status word with that bit at zero.

Top module: `q15_madd_unit`

## Requirements
- R1: After a synchronous active-high reset, `out_valid` is 0 and `status` reads 0x0000.
- R2: An operation accepted with `in_valid`=1 at a rising edge produces `out_valid`=1 and its `result` two rising edges later, for either operation. Back-to-back issues give back-to-back results, and `out_valid` is 0 in every other cycle.
- R3: With `op_sel`=0 (multiply), `result` is the Q30 product `opa*opb` plus 0x4000, arithmetically shifted right by 15, taken as 16 bits when it fits the signed 16-bit range. A dropped fraction of exactly one half rounds up, and a dropped fraction below one half rounds down.
- R4: The multiply of 0x8000 by 0x8000 gives 0x7FFF and sets the saturation flag.
- R5: With `op_sel`=1 (add), `result` is `opa+opb` whenever the sum fits in signed 16 bits.
- R6: An add that overflows gives 0x7FFF when the true sum is positive and 0x8000 when it is negative.
- R7: A result that was clipped sets `status` bit 9 in the same cycle that `out_valid` shows that result. An unclipped result leaves bit 9 unchanged.
- R8: Bit 9 stays set until `stat_wr`=1 with `stat_wdata[9]`=0. A write with `stat_wdata[9]`=1 has no effect on bit 9, and every other bit of `status` always reads 0.
- R9: If a clear write and a clipped result happen at the same edge, bit 9 is set after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue strobe for an operation |
| op_sel | input | 1 | 0 = rounded multiply, 1 = saturating add |
| opa | input | 16 | First Q15 operand |
| opb | input | 16 | Second Q15 operand |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 16 | Status write data; bit 9 = 0 clears the flag |
| out_valid | output | 1 | Result strobe, two cycles after issue |
| result | output | 16 | Q15 result |
| status | output | 16 | Status word; bit 9 is the sticky saturation flag |

## Verification
Every result and its flag update are due on the second rising edge after the edge that accepted the issue. A status write takes effect on the edge that captures it. The bench drives inputs on falling edges and samples on the falling edge after the edge on which a value is due. It also checks that `out_valid` is still low one cycle after an issue. The streaming test issues an operation every cycle and checks each output against the operands issued two cycles earlier. The simultaneous set-and-clear case places the clear write on the edge where a clipped result lands.

// File: rtl/q15_pkg.sv
package q15_pkg;
    typedef enum logic {
        OP_MUL = 1'b0,
        OP_ADD = 1'b1
    } q15_op_e;
endpackage

// File: rtl/q15_mul_round.sv
module q15_mul_round #(
    parameter int W    = 16,
    parameter int FRAC = 15
) (
    input  logic [2*W-1:0] prod_i,
    output logic [W-1:0]   res_o,
    output logic           sat_o
);
    localparam int PW = 2*W + 1;
    localparam logic [PW-1:0] RND = PW'(1) << (FRAC - 1);

    logic signed [PW-1:0] rnd_w;
    logic signed [PW-1:0] shr_w;
    logic                 fits_w;

    always_comb begin
        rnd_w  = $signed({prod_i[2*W-1], prod_i}) + $signed(RND);
        shr_w  = rnd_w >>> FRAC;
        fits_w = (&shr_w[PW-1:W-1]) || !(|shr_w[PW-1:W-1]);
        sat_o  = !fits_w;
        if (fits_w)
            res_o = shr_w[W-1:0];
        else if (shr_w[PW-1])
            res_o = {1'b1, {(W-1){1'b0}}};
        else
            res_o = {1'b0, {(W-1){1'b1}}};
    end
endmodule

// File: rtl/q15_add_clip.sv
module q15_add_clip #(
    parameter int W = 16
) (
    input  logic [W:0]   sum_i,
    output logic [W-1:0] res_o,
    output logic         sat_o
);
    always_comb begin
        sat_o = sum_i[W] ^ sum_i[W-1];
        if (!sat_o)
            res_o = sum_i[W-1:0];
        else if (sum_i[W])
            res_o = {1'b1, {(W-1){1'b0}}};
        else
            res_o = {1'b0, {(W-1){1'b1}}};
    end
endmodule

// File: rtl/q15_sat_flag.sv
module q15_sat_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic wr_i,
    input  logic wr_bit_i,
    output logic flag_o
);
    typedef struct packed {
        logic flag;
    } flag_t;

    flag_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        if (wr_i && !wr_bit_i)
            st_d.flag = 1'b0;
        if (set_i)
            st_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/q15_madd_unit.sv
module q15_madd_unit #(
    parameter int W        = 16,
    parameter int FRAC     = 15,
    parameter int STAT_W   = 16,
    parameter int FLAG_BIT = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              op_sel,
    input  logic [W-1:0]      opa,
    input  logic [W-1:0]      opb,
    input  logic              stat_wr,
    input  logic [STAT_W-1:0] stat_wdata,
    output logic              out_valid,
    output logic [W-1:0]      result,
    output logic [STAT_W-1:0] status
);
    import q15_pkg::*;

    localparam int PW = 2*W;

    typedef struct packed {
        logic          s1_valid;
        q15_op_e       s1_op;
        logic [PW-1:0] s1_prod;
        logic [W:0]    s1_sum;
        logic          s2_valid;
        logic [W-1:0]  s2_res;
        logic          s2_sat;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [W-1:0] mul_res_w, add_res_w;
    logic         mul_sat_w, add_sat_w;
    logic         flag_w;

    q15_mul_round #(.W(W), .FRAC(FRAC)) u_mul_round (
        .prod_i (pipe_q.s1_prod),
        .res_o  (mul_res_w),
        .sat_o  (mul_sat_w)
    );

    q15_add_clip #(.W(W)) u_add_clip (
        .sum_i  (pipe_q.s1_sum),
        .res_o  (add_res_w),
        .sat_o  (add_sat_w)
    );

    always_comb begin
        pipe_d          = pipe_q;
        pipe_d.s1_valid = in_valid;
        pipe_d.s1_op    = q15_op_e'(op_sel);
        pipe_d.s1_prod  = $signed({{W{opa[W-1]}}, opa}) * $signed({{W{opb[W-1]}}, opb});
        pipe_d.s1_sum   = {opa[W-1], opa} + {opb[W-1], opb};
        pipe_d.s2_valid = pipe_q.s1_valid;
        if (pipe_q.s1_op == OP_MUL) begin
            pipe_d.s2_res = mul_res_w;
            pipe_d.s2_sat = mul_sat_w && pipe_q.s1_valid;
        end else begin
            pipe_d.s2_res = add_res_w;
            pipe_d.s2_sat = add_sat_w && pipe_q.s1_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    q15_sat_flag u_sat_flag (
        .clk      (clk),
        .rst      (rst),
        .set_i    (pipe_d.s2_sat),
        .wr_i     (stat_wr),
        .wr_bit_i (stat_wdata[FLAG_BIT]),
        .flag_o   (flag_w)
    );

    always_comb begin
        for (int i = 0; i < STAT_W; i++)
            status[i] = (i == FLAG_BIT) ? flag_w : 1'b0;
    end

    assign out_valid = pipe_q.s2_valid;
    assign result    = pipe_q.s2_res;
endmodule

// File: rtl/q15_madd_chk.sv
module q15_madd_chk #(
    parameter int W        = 16,
    parameter int STAT_W   = 16,
    parameter int FLAG_BIT = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              stat_wr,
    input logic [STAT_W-1:0] stat_wdata,
    input logic              out_valid,
    input logic [W-1:0]      result,
    input logic [STAT_W-1:0] status
);
    localparam logic [W-1:0] QMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] QMIN = {1'b1, {(W-1){1'b0}}};

    logic [1:0] issue_hist;
    always_ff @(posedge clk) begin
        if (rst) issue_hist <= '0;
        else     issue_hist <= {issue_hist[0], in_valid};
    end

    // R2
    latency_two_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid == issue_hist[1]);

    // R7
    flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status[FLAG_BIT]) |-> (out_valid && (result == QMAX || result == QMIN)));

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (status[FLAG_BIT] && !(stat_wr && !stat_wdata[FLAG_BIT])) |=> status[FLAG_BIT]);

    // R8
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(status) == (status[FLAG_BIT] ? 1 : 0));
endmodule

bind q15_madd_unit q15_madd_chk #(.W(W), .STAT_W(STAT_W), .FLAG_BIT(FLAG_BIT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .stat_wr    (stat_wr),
    .stat_wdata (stat_wdata),
    .out_valid  (out_valid),
    .result     (result),
    .status     (status)
);

// File: tb/tb_q15_madd_unit.sv
module tb_q15_madd_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        op_sel;
    logic [15:0] opa, opb;
    logic        stat_wr;
    logic [15:0] stat_wdata;
    logic        out_valid;
    logic [15:0] result;
    logic [15:0] status;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    q15_madd_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .opa(opa), .opb(opb), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .out_valid(out_valid), .result(result), .status(status)
    );

    function automatic logic [15:0] ref_mul(input logic [15:0] a, input logic [15:0] b);
        longint p = longint'($signed(a)) * longint'($signed(b));
        longint r = (p + 16384) >>> 15;
        if (r > 32767)  return 16'h7FFF;
        if (r < -32768) return 16'h8000;
        return r[15:0];
    endfunction

    function automatic logic [15:0] ref_add(input logic [15:0] a, input logic [15:0] b);
        int s = int'($signed(a)) + int'($signed(b));
        if (s > 32767)  return 16'h7FFF;
        if (s < -32768) return 16'h8000;
        return s[15:0];
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_flag();
        @(negedge clk);
        stat_wr = 1'b1; stat_wdata = 16'h0000;
        @(negedge clk);
        stat_wr = 1'b0;
    endtask

    // Issue one op, check gap cycle and result cycle
    task automatic run_op(input string req, input logic op, input logic [15:0] a,
                          input logic [15:0] b, input logic [15:0] exp,
                          input logic [15:0] exp_stat);
        @(negedge clk);
        in_valid = 1'b1; op_sel = op; opa = a; opb = b;
        @(negedge clk);
        in_valid = 1'b0; opa = 16'h1234; opb = 16'h5678;
        check("R2 gap valid", 16'(out_valid), 16'h0);
        @(negedge clk);
        check("R2 valid", 16'(out_valid), 16'h1);
        check(req, result, exp);
        check("R7 status", status, exp_stat);
        @(negedge clk);
        check("R2 valid drop", 16'(out_valid), 16'h0);
    endtask

    task automatic t_reset();
        check("R1 out_valid", 16'(out_valid), 16'h0);
        check("R1 status", status, 16'h0000);
    endtask

    task automatic t_mul();
        run_op("R3 quarter", 1'b0, 16'h4000, 16'h4000, 16'h2000, 16'h0000);
        run_op("R3 half rounds up", 1'b0, 16'h0001, 16'h4000, 16'h0001, 16'h0000);
        run_op("R3 below half rounds down", 1'b0, 16'h0001, 16'h3FFF, 16'h0000, 16'h0000);
        run_op("R3 neg exact", 1'b0, 16'hFFFF, 16'h4000, 16'h0000, 16'h0000);
        run_op("R3 neg small", 1'b0, 16'hFFFF, 16'h4001, 16'hFFFF, 16'h0000);
        run_op("R3 min times max", 1'b0, 16'h8000, 16'h7FFF, 16'h8001, 16'h0000);
    endtask

    task automatic t_mul_sat();
        run_op("R4 minus one squared", 1'b0, 16'h8000, 16'h8000, 16'h7FFF, 16'h0200);
        clear_flag();
        check("R8 cleared", status, 16'h0000);
    endtask

    task automatic t_add();
        run_op("R5 plain", 1'b1, 16'h1234, 16'h0111, 16'h1345, 16'h0000);
        run_op("R5 cancel", 1'b1, 16'h4000, 16'hC000, 16'h0000, 16'h0000);
        run_op("R5 edge max", 1'b1, 16'h7000, 16'h0FFF, 16'h7FFF, 16'h0000);
        run_op("R6 pos clip", 1'b1, 16'h7000, 16'h1000, 16'h7FFF, 16'h0200);
        clear_flag();
        run_op("R6 neg clip", 1'b1, 16'h8000, 16'hFFFF, 16'h8000, 16'h0200);
        // R7: unclipped result keeps flag set
        run_op("R7 flag held", 1'b1, 16'h0001, 16'h0001, 16'h0002, 16'h0200);
    endtask

    task automatic t_sticky();
        // flag currently set; write with bit 9 = 1 has no effect
        @(negedge clk);
        stat_wr = 1'b1; stat_wdata = 16'hFFFF;
        @(negedge clk);
        stat_wr = 1'b0;
        check("R8 write one keeps", status, 16'h0200);
        repeat (3) @(negedge clk);
        check("R8 sticky idle", status, 16'h0200);
        clear_flag();
        check("R8 clear", status, 16'h0000);
        @(negedge clk);
        stat_wr = 1'b1; stat_wdata = 16'hFFFF;
        @(negedge clk);
        stat_wr = 1'b0;
        check("R8 write one from clear", status, 16'h0000);
    endtask

    task automatic t_simul();
        @(negedge clk);
        in_valid = 1'b1; op_sel = 1'b1; opa = 16'h7FFF; opb = 16'h7FFF;
        @(negedge clk);
        in_valid = 1'b0;
        stat_wr = 1'b1; stat_wdata = 16'h0000;
        @(negedge clk);
        stat_wr = 1'b0;
        check("R9 result", result, 16'h7FFF);
        check("R9 flag survives clear", status, 16'h0200);
        clear_flag();
        check("R9 later clear", status, 16'h0000);
    endtask

    task automatic t_stream();
        localparam int N = 24;
        logic [15:0] av [N];
        logic [15:0] bv [N];
        logic        ov [N];
        for (int i = 0; i < N; i++) begin
            av[i] = 16'(i * 16'h1C3B + 16'h0F11);
            bv[i] = 16'(16'hE7A5 - i * 16'h0B37);
            ov[i] = i[0];
        end
        for (int c = 0; c < N + 2; c++) begin
            @(negedge clk);
            if (c >= 2) begin
                check("R2 stream valid", 16'(out_valid), 16'h1);
                if (ov[c-2]) check("R5 stream add", result, ref_add(av[c-2], bv[c-2]));
                else         check("R3 stream mul", result, ref_mul(av[c-2], bv[c-2]));
            end
            if (c < N) begin
                in_valid = 1'b1; op_sel = ov[c]; opa = av[c]; opb = bv[c];
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        check("R2 stream end", 16'(out_valid), 16'h0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; op_sel = 1'b0; opa = '0; opb = '0;
        stat_wr = 1'b0; stat_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_mul();
        t_mul_sat();
        t_add();
        t_sticky();
        t_simul();
        t_stream();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule